// File: doc/BRIEF.md
# MADI Serial Symbol Aligner and Decoder

This block sits behind a bit-recovery stage on a MADI-style link. It turns a stream of recovered line bits into bytes. First it removes the NRZI line coding. Then it runs a sliding 10-bit window over the bits until the unique JK sync symbol appears. From that point it takes one symbol every ten bits and decodes each symbol as two 5-bit codes into one byte.

A symbol whose halves are valid codes but not both data is a command. The block reports it on its own strobe. Two configurable commands drive a side-band line level, which is enough to carry a slow UART or MIDI line alongside the audio. A byte that follows a JK symbol is marked as the first byte of a channel, so that later logic can find the frame-sync and channel-active bits.

Bits arrive with a `bit_valid` qualifier and cannot be stalled. The byte output is a valid/ready interface with these rules:
- `byte_valid` stays high, and `byte_data`/`byte_first` stay stable, until the cycle in which `byte_ready` is high.
- The serial side never waits. If a new byte is decoded while the previous one has not been accepted, the new byte replaces it.

Top module: `madi_sym_align`

## Requirements
- R1: The line is NRZI-decoded: a decoded bit is 1 when the line level differs from the previous line level seen with `bit_valid`, and 0 otherwise. The previous level resets to 0.
- R2: While not aligned, the last ten decoded bits are compared after every valid bit, with the earliest-received bit as MSB. A match with JK = 1100010001 sets `aligned` and pulses `sync_pulse`. No byte, command or error is reported while not aligned.
- R3: Once aligned, every tenth valid bit closes a symbol. Bits [9:5] are the first code and give the upper nibble; bits [4:0] give the lower nibble. The data codes for nibbles 0 to F are 11110, 01001, 10100, 10101, 01010, 01011, 01110, 01111, 10010, 10011, 10110, 10111, 11010, 11011, 11100, 11101. The byte appears one clock after the edge that samples the symbol's last bit.
- R4: The first data byte after a JK symbol has `byte_first` = 1. That applies to a JK found while hunting and to a JK at a symbol boundary while aligned. Every other byte has `byte_first` = 0.
- R5: A symbol that is not JK, whose halves are both drawn from the data codes or the control codes J=11000, K=10001, T=01101, R=00111, S=11001, I=11111, H=00100, and that is not two data codes, is a command. The block puts the full symbol on `cmd_code` and pulses `cmd_valid` for one cycle.
- R6: `line_state` resets to 1. The command T,T (0110101101) sets it to 1, and the command R,R (0011100111) clears it to 0. Any other command leaves it unchanged.
- R7: A symbol with any half outside both code sets pulses `dec_err` for one cycle and produces no byte and no command.
- R8: After 4 consecutive symbols that pulse `dec_err`, `aligned` falls and hunting resumes. A symbol without an invalid code clears the run.
- R9: `byte_valid` holds until `byte_ready` is high. A newer byte replaces an unaccepted one.
- R10: After reset, `aligned`, `byte_valid`, `cmd_valid`, `dec_err` and `sync_pulse` are 0 and `line_state` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| line_bit | input | 1 | Recovered NRZI line level |
| bit_valid | input | 1 | `line_bit` holds a new bit this cycle |
| byte_data | output | 8 | Decoded byte |
| byte_first | output | 1 | Byte is the first after a JK symbol |
| byte_valid | output | 1 | Byte available |
| byte_ready | input | 1 | Consumer accepts the byte |
| sync_pulse | output | 1 | JK symbol seen (one cycle) |
| cmd_code | output | 10 | Last command symbol |
| cmd_valid | output | 1 | New command (one cycle) |
| dec_err | output | 1 | Symbol held an invalid code (one cycle) |
| line_state | output | 1 | Side-band line level |
| aligned | output | 1 | Symbol boundaries locked |

## Verification
The stimulus is built to tell apart the cases the decoder must separate:
- A run of ones placed before the first JK puts the sync at an offset that is not a multiple of ten, which shows that the hunt slides bit by bit rather than by whole symbols.
- Data bytes spanning all-zero, all-one and mixed nibbles check the code table and the nibble order.
- Commands T,T, R,R and S,S show which symbols move the side-band line and which only report a code.
- Invalid symbols are sent as a run of three, then a good byte, then a run of four. This shows that only an unbroken run drops alignment, and that no bytes leak out while the block is hunting again.

// File: rtl/madi_pkg.sv
package madi_pkg;
  localparam int SYM_W  = 10;
  localparam int CODE_W = 5;
  localparam logic [SYM_W-1:0] JK_SYM = 10'b11000_10001;

  typedef struct packed {
    logic       is_data;
    logic       is_ctrl;
    logic [3:0] nib;
  } code5_t;

  function automatic code5_t decode5(input logic [CODE_W-1:0] c);
    code5_t r;
    r = '{is_data: 1'b1, is_ctrl: 1'b0, nib: 4'h0};
    case (c)
      5'b11110: r.nib = 4'h0;
      5'b01001: r.nib = 4'h1;
      5'b10100: r.nib = 4'h2;
      5'b10101: r.nib = 4'h3;
      5'b01010: r.nib = 4'h4;
      5'b01011: r.nib = 4'h5;
      5'b01110: r.nib = 4'h6;
      5'b01111: r.nib = 4'h7;
      5'b10010: r.nib = 4'h8;
      5'b10011: r.nib = 4'h9;
      5'b10110: r.nib = 4'hA;
      5'b10111: r.nib = 4'hB;
      5'b11010: r.nib = 4'hC;
      5'b11011: r.nib = 4'hD;
      5'b11100: r.nib = 4'hE;
      5'b11101: r.nib = 4'hF;
      5'b11000, 5'b10001, 5'b01101, 5'b00111,
      5'b11001, 5'b11111, 5'b00100: begin
        r.is_data = 1'b0;
        r.is_ctrl = 1'b1;
      end
      default: r.is_data = 1'b0;
    endcase
    return r;
  endfunction
endpackage

// File: rtl/madi_nrzi_dec.sv
module madi_nrzi_dec (
  input  logic clk,
  input  logic rst_n,
  input  logic line_bit,
  input  logic bit_valid,
  output logic bit_out
);
  logic prev_q;

  assign bit_out = line_bit ^ prev_q;

  always_ff @(posedge clk) begin
    if (!rst_n) prev_q <= 1'b0;
    else if (bit_valid) prev_q <= line_bit;
  end
endmodule

// File: rtl/madi_slip_aligner.sv
module madi_slip_aligner #(
  parameter int LOSS_COUNT = 4
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        bit_in,
  input  logic                        bit_valid,
  input  logic                        sym_bad,
  output logic [madi_pkg::SYM_W-1:0]  word,
  output logic                        sym_stb,
  output logic                        sync_hit,
  output logic                        aligned
);
  import madi_pkg::*;
  localparam int CNT_W = $clog2(SYM_W);
  localparam int ERR_W = $clog2(LOSS_COUNT + 1);

  logic [SYM_W-1:0] sr_q;
  logic [CNT_W-1:0] cnt_q;
  logic [ERR_W-1:0] errs_q;
  logic             hunt_hit;

  assign word     = {sr_q[SYM_W-2:0], bit_in};
  assign hunt_hit = bit_valid && !aligned && (word == JK_SYM);
  assign sym_stb  = bit_valid && aligned && (cnt_q == CNT_W'(SYM_W - 1));
  assign sync_hit = hunt_hit || (sym_stb && (word == JK_SYM));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sr_q    <= '0;
      cnt_q   <= '0;
      errs_q  <= '0;
      aligned <= 1'b0;
    end else begin
      if (bit_valid) sr_q <= word;
      if (hunt_hit) begin
        aligned <= 1'b1;
        cnt_q   <= '0;
        errs_q  <= '0;
      end else if (aligned && bit_valid) begin
        cnt_q <= sym_stb ? '0 : cnt_q + 1'b1;
        if (sym_stb) begin
          if (!sym_bad) begin
            errs_q <= '0;
          end else if (errs_q == ERR_W'(LOSS_COUNT - 1)) begin
            errs_q  <= '0;
            aligned <= 1'b0;
          end else begin
            errs_q <= errs_q + 1'b1;
          end
        end
      end
    end
  end
endmodule

// File: rtl/madi_sym_decode.sv
module madi_sym_decode (
  input  logic [madi_pkg::SYM_W-1:0] word,
  output logic                       both_data,
  output logic                       is_cmd,
  output logic                       bad,
  output logic [7:0]                 byte_val
);
  import madi_pkg::*;
  code5_t hi, lo;

  always_comb begin
    hi        = decode5(word[SYM_W-1:CODE_W]);
    lo        = decode5(word[CODE_W-1:0]);
    both_data = hi.is_data && lo.is_data;
    bad       = !(hi.is_data || hi.is_ctrl) || !(lo.is_data || lo.is_ctrl);
    is_cmd    = !bad && !both_data && (word != JK_SYM);
    byte_val  = {hi.nib, lo.nib};
  end
endmodule

// File: rtl/madi_sym_align.sv
module madi_sym_align #(
  parameter int                         LOSS_COUNT  = 4,
  parameter logic [madi_pkg::SYM_W-1:0] LINE_HI_SYM = 10'b01101_01101,
  parameter logic [madi_pkg::SYM_W-1:0] LINE_LO_SYM = 10'b00111_00111
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       line_bit,
  input  logic       bit_valid,
  output logic [7:0] byte_data,
  output logic       byte_first,
  output logic       byte_valid,
  input  logic       byte_ready,
  output logic       sync_pulse,
  output logic [9:0] cmd_code,
  output logic       cmd_valid,
  output logic       dec_err,
  output logic       line_state,
  output logic       aligned
);
  import madi_pkg::*;

  logic             dbit;
  logic [SYM_W-1:0] word;
  logic             sym_stb, sync_hit;
  logic             both_data, is_cmd, bad;
  logic [7:0]       byte_val;
  logic             first_pend;

  madi_nrzi_dec u_nrzi (
    .clk(clk), .rst_n(rst_n), .line_bit(line_bit),
    .bit_valid(bit_valid), .bit_out(dbit)
  );

  madi_slip_aligner #(.LOSS_COUNT(LOSS_COUNT)) u_align (
    .clk(clk), .rst_n(rst_n), .bit_in(dbit), .bit_valid(bit_valid),
    .sym_bad(bad), .word(word), .sym_stb(sym_stb),
    .sync_hit(sync_hit), .aligned(aligned)
  );

  madi_sym_decode u_dec (
    .word(word), .both_data(both_data), .is_cmd(is_cmd),
    .bad(bad), .byte_val(byte_val)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      byte_data  <= '0;
      byte_first <= 1'b0;
      byte_valid <= 1'b0;
      sync_pulse <= 1'b0;
      cmd_code   <= '0;
      cmd_valid  <= 1'b0;
      dec_err    <= 1'b0;
      line_state <= 1'b1;
      first_pend <= 1'b0;
    end else begin
      sync_pulse <= sync_hit;
      cmd_valid  <= sym_stb && is_cmd;
      dec_err    <= sym_stb && bad;
      if (byte_valid && byte_ready) byte_valid <= 1'b0;
      if (sync_hit) first_pend <= 1'b1;
      if (sym_stb && both_data) begin
        byte_data  <= byte_val;
        byte_first <= first_pend;
        byte_valid <= 1'b1;
        first_pend <= 1'b0;
      end
      if (sym_stb && is_cmd) begin
        cmd_code <= word;
        if (word == LINE_HI_SYM) line_state <= 1'b1;
        else if (word == LINE_LO_SYM) line_state <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/madi_sym_align_chk.sv
module madi_sym_align_chk (
  input logic clk,
  input logic rst_n,
  input logic byte_valid,
  input logic byte_ready,
  input logic sync_pulse,
  input logic cmd_valid,
  input logic dec_err,
  input logic line_state,
  input logic aligned
);
  p_cmd_not_err_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> !dec_err);
  p_sync_sets_align_r2: assert property (@(posedge clk) disable iff (!rst_n)
    sync_pulse |-> aligned);
  p_byte_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_valid && !byte_ready) |=> byte_valid);
  p_line_by_cmd_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(line_state) |-> cmd_valid);
  p_byte_needs_align_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(byte_valid) |-> aligned);
  p_cmd_one_cycle_r5: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |=> !cmd_valid);
endmodule

bind madi_sym_align madi_sym_align_chk chk_i (
  .clk(clk), .rst_n(rst_n), .byte_valid(byte_valid), .byte_ready(byte_ready),
  .sync_pulse(sync_pulse), .cmd_valid(cmd_valid), .dec_err(dec_err),
  .line_state(line_state), .aligned(aligned)
);

// File: tb/madi_sym_align_tb_top.sv
module madi_sym_align_tb_top;
  logic       clk = 0;
  logic       rst_n = 0;
  logic       line_bit = 0;
  logic       bit_valid = 0;
  logic       byte_ready = 1;
  logic [7:0] byte_data;
  logic       byte_first, byte_valid, sync_pulse, cmd_valid, dec_err;
  logic       line_state, aligned;
  logic [9:0] cmd_code;

  int checks = 0;
  int fails = 0;
  logic       line_lvl = 0;
  logic [8:0] exp_q[$];
  bit         done = 0;

  always #5 clk = ~clk;

  madi_sym_align dut_i (
    .clk(clk), .rst_n(rst_n), .line_bit(line_bit), .bit_valid(bit_valid),
    .byte_data(byte_data), .byte_first(byte_first), .byte_valid(byte_valid),
    .byte_ready(byte_ready), .sync_pulse(sync_pulse), .cmd_code(cmd_code),
    .cmd_valid(cmd_valid), .dec_err(dec_err), .line_state(line_state),
    .aligned(aligned)
  );

  function automatic logic [4:0] enc4(input logic [3:0] n);
    case (n)
      4'h0: return 5'b11110; 4'h1: return 5'b01001;
      4'h2: return 5'b10100; 4'h3: return 5'b10101;
      4'h4: return 5'b01010; 4'h5: return 5'b01011;
      4'h6: return 5'b01110; 4'h7: return 5'b01111;
      4'h8: return 5'b10010; 4'h9: return 5'b10011;
      4'hA: return 5'b10110; 4'hB: return 5'b10111;
      4'hC: return 5'b11010; 4'hD: return 5'b11011;
      4'hE: return 5'b11100; default: return 5'b11101;
    endcase
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic send_bit(input logic b);
    @(negedge clk);
    line_lvl  = line_lvl ^ b;
    line_bit  = line_lvl;
    bit_valid = 1;
  endtask

  task automatic send_sym(input logic [9:0] s);
    for (int i = 9; i >= 0; i--) send_bit(s[i]);
    @(negedge clk);
    bit_valid = 0;
  endtask

  task automatic send_byte(input logic [7:0] b, input logic first, input logic expect_out);
    if (expect_out) exp_q.push_back({first, b});
    send_sym({enc4(b[7:4]), enc4(b[3:0])});
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (rst_n && byte_valid && byte_ready) begin
      checks++;
      if (exp_q.size() == 0) begin
        fails++;
        $display("FAIL R2/R3 unexpected byte actual=%0h expected=none", {byte_first, byte_data});
      end else begin
        logic [8:0] e;
        e = exp_q.pop_front();
        if ({byte_first, byte_data} !== e) begin
          fails++;
          $display("FAIL R3/R4 byte actual=%0h expected=%0h", {byte_first, byte_data}, e);
        end
      end
    end
  end

  initial begin
    for (int c = 0; c < 100000 && !done; c++) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R10 aligned", aligned, 0);
    chk("R10 byte_valid", byte_valid, 0);
    chk("R10 line_state", line_state, 1);
    chk("R10 cmd/err/sync", {cmd_valid, dec_err, sync_pulse}, 0);

    // R2: junk of seven ones, then JK at odd offset
    for (int i = 0; i < 7; i++) send_bit(1'b1);
    @(negedge clk); bit_valid = 0;
    chk("R2 no align on junk", aligned, 0);
    send_sym(10'b11000_10001);
    chk("R2 sync pulse", sync_pulse, 1);
    chk("R2 aligned", aligned, 1);

    // R1/R3/R4 data bytes
    send_byte(8'hA5, 1, 1);
    send_byte(8'h3C, 0, 1);
    send_byte(8'h00, 0, 1);
    send_byte(8'hFF, 0, 1);

    // R5/R6 commands
    send_sym(10'b01101_01101);
    chk("R5 cmd_valid TT", cmd_valid, 1);
    chk("R5 cmd_code TT", cmd_code, 10'b0110101101);
    chk("R6 line after TT", line_state, 1);
    send_sym(10'b00111_00111);
    chk("R6 line after RR", line_state, 0);
    send_sym(10'b11001_11001);
    chk("R5 cmd_code SS", cmd_code, 10'b1100111001);
    chk("R6 line unchanged by SS", line_state, 0);
    send_byte(8'h69, 0, 1);
    chk("R5 no cmd on data", cmd_valid, 0);

    // R4 JK while aligned
    send_sym(10'b11000_10001);
    chk("R4 sync aligned", sync_pulse, 1);
    chk("R5 JK not cmd", cmd_valid, 0);
    send_byte(8'h7E, 1, 1);
    send_byte(8'h81, 0, 1);

    // R9 back-pressure
    @(posedge clk); #1 byte_ready = 0;
    send_byte(8'h11, 0, 0);
    send_byte(8'h22, 0, 0);
    repeat (2) @(negedge clk);
    chk("R9 held valid", byte_valid, 1);
    chk("R9 replaced data", byte_data, 8'h22);
    exp_q.push_back({1'b0, 8'h22});
    @(posedge clk); #1 byte_ready = 1;
    repeat (3) @(negedge clk);
    chk("R9 released", byte_valid, 0);

    // R7/R8 errors
    for (int i = 0; i < 3; i++) begin
      send_sym(10'b00000_00000);
      chk("R7 dec_err", dec_err, 1);
    end
    chk("R8 still aligned after 3", aligned, 1);
    send_byte(8'h12, 0, 1);
    chk("R7 no err on data", dec_err, 0);
    for (int i = 0; i < 3; i++) send_sym(10'b00000_00000);
    chk("R8 aligned after 3 again", aligned, 1);
    send_sym(10'b00000_00000);
    chk("R8 lost after 4", aligned, 0);
    send_byte(8'h55, 0, 0);
    send_byte(8'h55, 0, 0);
    chk("R2 hunting no byte", byte_valid, 0);
    chk("R2 still hunting", aligned, 0);

    // re-sync
    send_sym(10'b11000_10001);
    chk("R2 resync", aligned, 1);
    send_byte(8'hC3, 1, 1);
    repeat (3) @(negedge clk);
    chk("R3 all bytes seen", exp_q.size(), 0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule